// File: doc/BRIEF.md
# Primary-Clock Idle Sequencer

This block moves a processor core into and out of an idle state in which only the CPU clock stops. The primary oscillator and the peripheral clock keep running the whole time. Software requests idle by setting the idle-enable control bit, writing all zeros to the two-bit clock select field, and then executing a sleep instruction, which the core signals with a one-cycle strobe. The block turns off the CPU clock enable at the next instruction-cycle boundary. Each instruction cycle has four phases, tracked by a free-running counter, and the boundary is the start of the first phase. Clock enables therefore switch only on that boundary, so the gated clock never glitches.

A wake event turns the CPU clock enable back on at the next boundary. The oscillator never stopped, so it needs no warm-up. Execution still waits for a fixed start-up delay, which is a down-counter loaded from a parameter set to the number of primary cycles in about 10 µs. When the delay expires, CPU-ready rises and a one-cycle program-counter advance pulse tells the core to resume at the instruction after the sleep. A sleep strobe that does not qualify for this mode is passed on through a full-sleep request pulse and has no other effect here. The oscillator start-up status output stays set throughout.

Top module: `idle_clk_ctrl`

## Requirements
- R1: After reset, cpuClkEn, periClkEn, oscReady and cpuReady are 1, and fullSleepReq and pcAdvance are 0.
- R2: In the running state, a sleepStb sampled while idleEn is 1 and clkSel is 2'b00 drives cpuClkEn and cpuReady to 0 within PHASES clock edges.
- R3: periClkEn stays 1 at all times after reset, including in idle and during start-up.
- R4: oscReady stays 1 on entry to idle, during idle and after wake.
- R5: cpuClkEn changes only on a clock edge whose count since reset release is a multiple of PHASES (PHASES = 4). That edge is where phase Q1 starts.
- R6: In the running state, a sleepStb sampled while idleEn is 0 or clkSel is not 2'b00 leaves cpuClkEn at 1. It raises fullSleepReq for exactly the one cycle after the strobe edge.
- R7: In idle, a wakeEvt sets cpuClkEn back to 1 at the next Q1 boundary, while cpuReady stays 0.
- R8: cpuReady rises exactly STARTUP_CYC clock cycles after cpuClkEn returns to 1.
- R9: Wake events during the start-up delay neither restart nor shorten the count.
- R10: pcAdvance is a one-cycle pulse in the same cycle that cpuReady rises after a wake.
- R11: sleepStb pulses while in idle are ignored: no fullSleepReq pulse, and cpuClkEn stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| idleEn | input | 1 | Idle-enable control bit |
| clkSel | input | SEL_W | System clock select field; only all zeros allows primary idle |
| sleepStb | input | 1 | One-cycle strobe for an executed sleep instruction |
| wakeEvt | input | 1 | Wake event |
| cpuClkEn | output | 1 | CPU clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| oscReady | output | 1 | Oscillator start-up status flag |
| cpuReady | output | 1 | CPU may execute instructions |
| fullSleepReq | output | 1 | Pulse for a sleep request that does not qualify for primary idle |
| pcAdvance | output | 1 | Pulse telling the core to resume at the next instruction |

## Verification
A corrupted sequencer state shows up first on cpuClkEn. Two faults are visible within one instruction cycle: a gate that moves off the Q1 boundary, or an enable that never drops after a qualifying sleep. A corrupted start-up counter is visible only when cpuReady rises, so the bench counts the exact number of cycles from the re-enabled clock to ready, with stray wakes injected partway through. Wrong qualification of a sleep request appears one cycle after the strobe, as a missing or unexpected fullSleepReq pulse.

// File: rtl/idle_clk_pkg.sv
package idle_clk_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENTER,
    ST_IDLE,
    ST_WAKE,
    ST_START
  } idleState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic gateCpu;    // stop CPU clock, drop ready
    logic ungateCpu;  // restart CPU clock, load start-up count
    logic countEn;    // decrement start-up count
    logic setReady;   // start-up delay done
    logic fullSleep;  // non-qualifying sleep request
  } ctrlStrb_t;

endpackage

// File: rtl/idle_clk_fsm.sv
module idle_clk_fsm
  import idle_clk_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idleEn,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             sleepStb,
  input  logic             wakeEvt,
  input  logic             qLast,
  input  logic             cntZero,
  output ctrlStrb_t        strb
);

  idleState_t state, stateNxt;
  logic qualifies;

  assign qualifies = idleEn && (clkSel == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_RUN: begin
        if (sleepStb) begin
          if (qualifies) stateNxt = ST_ENTER;
          else           strb.fullSleep = 1'b1;
        end
      end
      ST_ENTER: begin
        if (qLast) begin
          strb.gateCpu = 1'b1;
          stateNxt     = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (wakeEvt) stateNxt = ST_WAKE;
      end
      ST_WAKE: begin
        if (qLast) begin
          strb.ungateCpu = 1'b1;
          stateNxt       = ST_START;
        end
      end
      ST_START: begin
        if (cntZero) begin
          strb.setReady = 1'b1;
          stateNxt      = ST_RUN;
        end else begin
          strb.countEn = 1'b1;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end

endmodule

// File: rtl/idle_clk_dp.sv
module idle_clk_dp
  import idle_clk_pkg::*;
#(
  parameter int PHASES      = 4,
  parameter int STARTUP_CYC = 400,
  localparam int PH_W       = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int CNT_W      = $clog2(STARTUP_CYC + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrb_t       strb,
  output logic [PH_W-1:0] qPhase,
  output logic            qLast,
  output logic            cntZero,
  output logic            cpuClkEn,
  output logic            periClkEn,
  output logic            oscReady,
  output logic            cpuReady,
  output logic            fullSleepReq,
  output logic            pcAdvance
);

  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PHASES - 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STARTUP_CYC - 1);

  logic [CNT_W-1:0] startCnt;

  assign qLast   = (qPhase == PH_LAST);
  assign cntZero = (startCnt == '0);

  // free-running instruction-cycle phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      qPhase <= '0;
    else if (qLast) qPhase <= '0;
    else            qPhase <= qPhase + 1'b1;
  end

  // start-up delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        startCnt <= '0;
    else if (strb.ungateCpu)          startCnt <= CNT_LOAD;
    else if (strb.countEn && !cntZero) startCnt <= startCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuClkEn     <= 1'b1;
      cpuReady     <= 1'b1;
      periClkEn    <= 1'b1;
      oscReady     <= 1'b1;
      fullSleepReq <= 1'b0;
      pcAdvance    <= 1'b0;
    end else begin
      if (strb.gateCpu)        cpuClkEn <= 1'b0;
      else if (strb.ungateCpu) cpuClkEn <= 1'b1;
      if (strb.gateCpu)        cpuReady <= 1'b0;
      else if (strb.setReady)  cpuReady <= 1'b1;
      periClkEn    <= 1'b1;
      oscReady     <= 1'b1;
      fullSleepReq <= strb.fullSleep;
      pcAdvance    <= strb.setReady;
    end
  end

endmodule

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl
  import idle_clk_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int PHASES      = 4,
  parameter int STARTUP_CYC = 400,
  localparam int PH_W       = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idleEn,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             sleepStb,
  input  logic             wakeEvt,
  output logic             cpuClkEn,
  output logic             periClkEn,
  output logic             oscReady,
  output logic             cpuReady,
  output logic             fullSleepReq,
  output logic             pcAdvance
);

  ctrlStrb_t       strb;
  logic            qLast;
  logic            cntZero;
  logic [PH_W-1:0] qPhase;

  idle_clk_fsm #(.SEL_W(SEL_W)) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .idleEn   (idleEn),
    .clkSel   (clkSel),
    .sleepStb (sleepStb),
    .wakeEvt  (wakeEvt),
    .qLast    (qLast),
    .cntZero  (cntZero),
    .strb     (strb)
  );

  idle_clk_dp #(.PHASES(PHASES), .STARTUP_CYC(STARTUP_CYC)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .qPhase       (qPhase),
    .qLast        (qLast),
    .cntZero      (cntZero),
    .cpuClkEn     (cpuClkEn),
    .periClkEn    (periClkEn),
    .oscReady     (oscReady),
    .cpuReady     (cpuReady),
    .fullSleepReq (fullSleepReq),
    .pcAdvance    (pcAdvance)
  );

endmodule

// File: rtl/idle_clk_chk.sv
module idle_clk_chk #(
  parameter int SEL_W  = 2,
  parameter int PHASES = 4,
  localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             idleEn,
  input logic [SEL_W-1:0] clkSel,
  input logic             sleepStb,
  input logic             cpuClkEn,
  input logic             periClkEn,
  input logic             oscReady,
  input logic             cpuReady,
  input logic             fullSleepReq,
  input logic             pcAdvance,
  input logic [PH_W-1:0]  qPhase
);

  // R3
  peri_clk_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    periClkEn);

  // R4
  osc_status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscReady);

  // R5
  gate_on_q1_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cpuClkEn) |-> (qPhase == '0));

  // R7
  ready_needs_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuClkEn |-> !cpuReady);

  // R10
  pc_adv_with_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuReady) |-> pcAdvance);

  // R10
  pc_adv_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcAdvance |=> !pcAdvance);

  // R6
  full_sleep_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullSleepReq |-> ($past(sleepStb) && !($past(idleEn) && ($past(clkSel) == '0))));

endmodule

bind idle_clk_ctrl idle_clk_chk #(.SEL_W(SEL_W), .PHASES(PHASES)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .idleEn       (idleEn),
  .clkSel       (clkSel),
  .sleepStb     (sleepStb),
  .cpuClkEn     (cpuClkEn),
  .periClkEn    (periClkEn),
  .oscReady     (oscReady),
  .cpuReady     (cpuReady),
  .fullSleepReq (fullSleepReq),
  .pcAdvance    (pcAdvance),
  .qPhase       (qPhase)
);

// File: tb/tb_idle_clk_ctrl.sv
module tb_idle_clk_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int STARTUP    = 25;
  localparam int PHASES     = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       idleEn = 1'b0;
  logic [1:0] clkSel = 2'b00;
  logic       sleepStb = 1'b0;
  logic       wakeEvt = 1'b0;
  logic       cpuClkEn, periClkEn, oscReady, cpuReady, fullSleepReq, pcAdvance;

  int nChecks = 0;
  int nFail   = 0;
  int edgeCnt;

  idle_clk_ctrl #(.SEL_W(2), .PHASES(PHASES), .STARTUP_CYC(STARTUP)) dut (
    .clk(clk), .rstN(rstN), .idleEn(idleEn), .clkSel(clkSel),
    .sleepStb(sleepStb), .wakeEvt(wakeEvt), .cpuClkEn(cpuClkEn),
    .periClkEn(periClkEn), .oscReady(oscReady), .cpuReady(cpuReady),
    .fullSleepReq(fullSleepReq), .pcAdvance(pcAdvance)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    step(); step();
    check("R1", "cpuClkEn in reset", cpuClkEn, 1);
    check("R1", "cpuReady in reset", cpuReady, 1);
    check("R1", "fullSleepReq in reset", fullSleepReq, 0);
    rstN = 1'b1;
    step();
    check("R1", "periClkEn after reset", periClkEn, 1);
    check("R1", "oscReady after reset", oscReady, 1);
    check("R1", "pcAdvance after reset", pcAdvance, 0);
  endtask

  task automatic test_reject(logic ie, logic [1:0] sel, string what);
    int stayed;
    idleEn = ie; clkSel = sel; sleepStb = 1'b1;
    step();
    sleepStb = 1'b0;
    check("R6", {what, " fullSleepReq pulse"}, fullSleepReq, 1);
    step();
    check("R6", {what, " fullSleepReq single cycle"}, fullSleepReq, 0);
    stayed = 0;
    for (int i = 0; i < 8; i++) begin
      if (cpuClkEn) stayed++;
      step();
    end
    check("R6", {what, " cpuClkEn kept"}, stayed, 8);
  endtask

  task automatic test_enter();
    int n;
    idleEn = 1'b1; clkSel = 2'b00; sleepStb = 1'b1;
    step();
    sleepStb = 1'b0;
    n = 1;
    while (cpuClkEn && n < 2 * PHASES) begin step(); n++; end
    check("R2", "cpuClkEn gated", cpuClkEn, 0);
    check("R2", "cpuReady dropped", cpuReady, 0);
    check("R5", "gate edge phase", edgeCnt % PHASES, 0);
    check("R3", "periClkEn in idle", periClkEn, 1);
    check("R4", "oscReady in idle", oscReady, 1);
  endtask

  task automatic test_idle_sleep();
    int gated;
    sleepStb = 1'b1;
    step();
    sleepStb = 1'b0;
    check("R11", "no fullSleepReq in idle", fullSleepReq, 0);
    gated = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (!cpuClkEn) gated++;
    end
    check("R11", "cpuClkEn stays gated", gated, 6);
  endtask

  task automatic test_wake();
    int n;
    int kept;
    wakeEvt = 1'b1;
    step();
    wakeEvt = 1'b0;
    n = 1;
    while (!cpuClkEn && n < 2 * PHASES) begin step(); n++; end
    check("R7", "cpuClkEn restored", cpuClkEn, 1);
    check("R7", "cpuReady still low", cpuReady, 0);
    check("R5", "ungate edge phase", edgeCnt % PHASES, 0);
    n = 0;
    while (!cpuReady && n < STARTUP + 20) begin
      step();
      n++;
      wakeEvt = (n == 5 || n == 12 || n == STARTUP - 2);
      if (n == STARTUP / 2) check("R3", "periClkEn in start-up", periClkEn, 1);
    end
    wakeEvt = 1'b0;
    check("R8", "start-up cycles (R9 stray wakes)", n, STARTUP);
    check("R10", "pcAdvance with ready", pcAdvance, 1);
    check("R4", "oscReady after wake", oscReady, 1);
    step();
    check("R10", "pcAdvance one cycle", pcAdvance, 0);
    kept = 0;
    for (int i = 0; i < 8; i++) begin
      if (cpuClkEn && cpuReady) kept++;
      step();
    end
    check("R9", "running after stray wakes", kept, 8);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    test_reset();
    test_reject(1'b0, 2'b00, "idleEn clear");
    test_reject(1'b1, 2'b01, "clkSel nonzero");
    test_enter();
    test_idle_sleep();
    test_wake();
    step(); step(); step();
    test_enter();
    test_wake();
    test_reject(1'b1, 2'b10, "clkSel upper bit");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule